// File: doc/BRIEF.md
# Collision and Synchronization Status Register

This block is an 8-bit status register for a half-duplex packet link. The link closes each frame with a line code violation. The register latches four kinds of event that the surrounding logic reports:

- **Collision field.** Records the transmit phase in which a collision pulse arrived. The first phase seen is kept.
- **Sync-fail flag.** Set when the packet-cycle timer runs out after the link is enabled, before initial synchronization has been reached.
- **Improper-violation flag.** Set when a received line code violation is too short.
- **Transmit-fail flag.** Set on a transmit failure. The same event also makes the block send a one-cycle pulse that withdraws the pending transmit request.

Software reads the register through a simple port that is always readable, and clears bits through a write strobe. The three clear rules are different:

- The collision field clears only when the all-ones code is written to it.
- The improper-violation and transmit-fail flags are write-one-to-clear.
- The sync-fail flag ignores writes and clears only when the enable input goes low.

The line coder, the bit timing recovery and the packet-cycle timer are outside this block. Their results arrive as inputs.

Top module: `lcsr_status`

## Requirements
- R1: After synchronous reset, `rd_data` is 8'h00 and `tx_req_clear` is 0. Bits 7:5 of `rd_data` always read as zero, whatever value is written to them.
- R2: A collision pulse with an empty collision field stores the phase code in `rd_data[3:2]` on the next edge. Phase codes: 2'b01 preamble, 2'b10 data, 2'b11 line code violation.
- R3: A collision pulse while `tx_phase` is 2'b00 (idle) leaves the collision field unchanged.
- R4: Once the collision field is non-zero, later collision pulses in any phase leave it unchanged.
- R5: The collision field returns to 2'b00 only on a write with `wr_data[3:2]` = 2'b11. Writes with 2'b00, 2'b01 or 2'b10 in those bits leave it unchanged.
- R6: `rd_data[4]` (sync-fail) sets when `link_en` is 1, `cycle_expired` pulses, and no `sync_done` has been seen since `link_en` last rose. If sync was reached, expiry does not set it.
- R7: The sync-fail flag clears on the edge after `link_en` is sampled 0. Register writes have no effect on it.
- R8: When `lcv_done` pulses with `lcv_len` below 3 bit periods, `rd_data[1]` (improper violation) sets. A length of 3 or more does not set it. Writing 1 to bit 1 clears it.
- R9: `tx_fail_evt` sets `rd_data[0]`, and a write of 1 to bit 0 clears it. `tx_req_clear` is high for exactly the one cycle after each `tx_fail_evt` cycle.
- R10: When a set event and a software clear of the same bit (bits 0, 1 or 3:2) land in one cycle, the bit ends up set. For the collision field, it holds the new phase code.
- R11: Writing 0 to bit 0 or bit 1 leaves that bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coll_pulse | input | 1 | Valid collision pulse strobe |
| tx_phase | input | 2 | Transmit phase: 00 idle, 01 preamble, 10 data, 11 violation |
| lcv_done | input | 1 | Strobe: a received line code violation has ended |
| lcv_len | input | 4 | Measured violation length in bit periods |
| link_en | input | 1 | Link enable bit |
| cycle_expired | input | 1 | Packet-cycle timer expiry strobe |
| sync_done | input | 1 | Initial synchronization achieved strobe |
| tx_fail_evt | input | 1 | Transmit failure strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| tx_req_clear | output | 1 | One-cycle pulse that clears the transmit request |

## Verification
Collisions are driven in each of the three active phases from an empty field, so that every encoding appears on its own. They are also driven in idle, and in a second phase after a first capture, which tells the sticky hold apart from overwriting. The clear rules are exercised with every 2-bit write pattern on the collision field and with zero and one writes on the other flags. These show which bits answer to which clear mechanism. Violation lengths of 2 and 3 sit on either side of the threshold. Timer expiry is tried both with and without a prior sync strobe, and a same-cycle set and clear shows that the set takes priority.

// File: rtl/lcsr_pkg.sv
package lcsr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'b00,
        PH_PREAMBLE = 2'b01,
        PH_DATA     = 2'b10,
        PH_VIOL     = 2'b11
    } tx_phase_e;

    localparam int STS_W       = 8;
    localparam int BIT_TXFAIL  = 0;
    localparam int BIT_IMPROP  = 1;
    localparam int BIT_COLL_LO = 2;
    localparam int BIT_SYNCF   = 4;
    localparam int N_W1C       = 2;

    typedef struct packed {
        logic [1:0] coll;
        logic       sync_fail;
        logic       improper;
        logic       tx_fail;
    } sts_flags_t;

    function automatic logic [STS_W-1:0] pack_status(sts_flags_t f);
        logic [STS_W-1:0] v;
        v = '0;
        v[BIT_TXFAIL]                  = f.tx_fail;
        v[BIT_IMPROP]                  = f.improper;
        v[BIT_COLL_LO+1:BIT_COLL_LO]   = f.coll;
        v[BIT_SYNCF]                   = f.sync_fail;
        return v;
    endfunction

endpackage

// File: rtl/lcsr_w1c_bit.sv
module lcsr_w1c_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q);
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> q == $past(q));
endmodule

// File: rtl/lcsr_coll_capture.sv
module lcsr_coll_capture
    import lcsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      coll_pulse,
    input  tx_phase_e phase,
    input  logic      clr_i,
    output logic [1:0] coll_q
);
    logic       empty_after_clr;
    logic       capture;

    assign empty_after_clr = (coll_q == 2'b00) || clr_i;
    assign capture = coll_pulse && (phase != PH_IDLE) && empty_after_clr;

    always_ff @(posedge clk) begin
        if (rst)          coll_q <= 2'b00;
        else if (capture) coll_q <= phase;
        else if (clr_i)   coll_q <= 2'b00;
    end

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (coll_q != 2'b00 && !clr_i) |=> coll_q == $past(coll_q));
    assert_idle_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (coll_q == 2'b00 && phase == PH_IDLE) |=> coll_q == 2'b00);
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (coll_q == 2'b00 && coll_pulse && phase != PH_IDLE)
            |=> coll_q == $past(phase));
endmodule

// File: rtl/lcsr_sync_watch.sv
module lcsr_sync_watch (
    input  logic clk,
    input  logic rst,
    input  logic link_en,
    input  logic cycle_expired,
    input  logic sync_done,
    output logic sync_fail
);
    logic synced_q;
    logic reached;

    assign reached = synced_q || sync_done;

    always_ff @(posedge clk) begin
        if (rst || !link_en) begin
            synced_q  <= 1'b0;
            sync_fail <= 1'b0;
        end else begin
            if (sync_done) synced_q <= 1'b1;
            if (cycle_expired && !reached) sync_fail <= 1'b1;
        end
    end

    assert_clear_on_disable_R7: assert property (@(posedge clk) disable iff (rst)
        !link_en |=> !sync_fail);
    assert_no_fail_after_sync_R6: assert property (@(posedge clk) disable iff (rst)
        (link_en && synced_q && !sync_fail) |=> !sync_fail);
endmodule

// File: rtl/lcsr_status.sv
module lcsr_status
    import lcsr_pkg::*;
#(
    parameter int LEN_W        = 4,
    parameter int MIN_LCV_BITS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             coll_pulse,
    input  logic [1:0]       tx_phase,
    input  logic             lcv_done,
    input  logic [LEN_W-1:0] lcv_len,
    input  logic             link_en,
    input  logic             cycle_expired,
    input  logic             sync_done,
    input  logic             tx_fail_evt,
    input  logic             wr_en,
    input  logic [STS_W-1:0] wr_data,
    output logic [STS_W-1:0] rd_data,
    output logic             tx_req_clear
);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_LCV_BITS);
    localparam int W1C_POS [N_W1C] = '{BIT_TXFAIL, BIT_IMPROP};

    sts_flags_t   flags;
    logic [N_W1C-1:0] w1c_set, w1c_clr, w1c_q;
    logic         coll_clr;
    logic         short_lcv;

    assign short_lcv = lcv_done && (lcv_len < MIN_LEN);
    assign w1c_set   = {short_lcv, tx_fail_evt};
    assign coll_clr  = wr_en && (wr_data[BIT_COLL_LO+1:BIT_COLL_LO] == 2'b11);

    for (genvar i = 0; i < N_W1C; i++) begin : g_w1c
        assign w1c_clr[i] = wr_en && wr_data[W1C_POS[i]];
        lcsr_w1c_bit u_bit (
            .clk   (clk),
            .rst   (rst),
            .set_i (w1c_set[i]),
            .clr_i (w1c_clr[i]),
            .q     (w1c_q[i])
        );
    end

    lcsr_coll_capture u_coll (
        .clk        (clk),
        .rst        (rst),
        .coll_pulse (coll_pulse),
        .phase      (tx_phase_e'(tx_phase)),
        .clr_i      (coll_clr),
        .coll_q     (flags.coll)
    );

    lcsr_sync_watch u_sync (
        .clk           (clk),
        .rst           (rst),
        .link_en       (link_en),
        .cycle_expired (cycle_expired),
        .sync_done     (sync_done),
        .sync_fail     (flags.sync_fail)
    );

    assign flags.tx_fail  = w1c_q[0];
    assign flags.improper = w1c_q[1];
    assign rd_data        = pack_status(flags);

    always_ff @(posedge clk) begin
        if (rst) tx_req_clear <= 1'b0;
        else     tx_req_clear <= tx_fail_evt;
    end

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:5] == 3'b000);
    assert_txreq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        tx_fail_evt |=> (tx_req_clear && rd_data[BIT_TXFAIL]));
    assert_improper_set_R8: assert property (@(posedge clk) disable iff (rst)
        (lcv_done && lcv_len < MIN_LEN) |=> rd_data[BIT_IMPROP]);
    assert_long_lcv_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[BIT_IMPROP] && !(lcv_done && lcv_len < MIN_LEN)) |=> !rd_data[BIT_IMPROP]);
endmodule

// File: tb/lcsr_status_test.sv
`timescale 1ns/1ps
module lcsr_status_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       coll_pulse, lcv_done, link_en, cycle_expired, sync_done;
    logic       tx_fail_evt, wr_en, tx_req_clear;
    logic [1:0] tx_phase;
    logic [3:0] lcv_len;
    logic [7:0] wr_data, rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lcsr_status uut (
        .clk(clk), .rst(rst), .coll_pulse(coll_pulse), .tx_phase(tx_phase),
        .lcv_done(lcv_done), .lcv_len(lcv_len), .link_en(link_en),
        .cycle_expired(cycle_expired), .sync_done(sync_done),
        .tx_fail_evt(tx_fail_evt), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tx_req_clear(tx_req_clear)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        coll_pulse = 0; tx_phase = 2'b00; lcv_done = 0; lcv_len = 0;
        cycle_expired = 0; sync_done = 0; tx_fail_evt = 0;
        wr_en = 0; wr_data = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d; cyc();
    endtask

    task automatic coll(input logic [1:0] ph);
        coll_pulse = 1; tx_phase = ph; cyc();
    endtask

    task automatic do_reset();
        rst = 1; link_en = 0; idle_inputs();
        repeat (2) @(negedge clk);
        rst = 0;
        cyc();
    endtask

    task automatic t_reset();
        chk("R1 reset value", rd_data, 8'h00);
        chk("R1 tx_req_clear reset", {7'b0, tx_req_clear}, 8'h00);
        wr(8'hE0);
        chk("R1 reserved bits read zero", rd_data, 8'h00);
    endtask

    task automatic t_coll_encode();
        logic [1:0] ph;
        for (int i = 1; i < 4; i++) begin
            ph = 2'(i);
            coll(ph);
            chk("R2 collision phase code", rd_data, {4'b0, ph, 2'b00});
            wr(8'h0C);
        end
        chk("R5 clear with 11", rd_data, 8'h00);
    endtask

    task automatic t_coll_idle();
        coll(2'b00);
        chk("R3 idle collision ignored", rd_data, 8'h00);
    endtask

    task automatic t_coll_sticky();
        coll(2'b01);
        coll(2'b10);
        chk("R4 sticky after data collision", rd_data, 8'h04);
        coll(2'b11);
        chk("R4 sticky after violation collision", rd_data, 8'h04);
        wr(8'h08);
        chk("R5 write 10 no clear", rd_data, 8'h04);
        wr(8'h04);
        chk("R5 write 01 no clear", rd_data, 8'h04);
        wr(8'h00);
        chk("R5 write 00 no clear", rd_data, 8'h04);
        wr(8'h0C);
        chk("R5 write 11 clears", rd_data, 8'h00);
    endtask

    task automatic t_sync();
        link_en = 1; cyc();
        cycle_expired = 1; cyc();
        chk("R6 expiry without sync sets", rd_data, 8'h10);
        wr(8'hFF);
        chk("R7 write does not clear sync-fail", rd_data, 8'h10);
        link_en = 0; cyc();
        chk("R7 disable clears sync-fail", rd_data, 8'h00);
        link_en = 1; cyc();
        sync_done = 1; cyc();
        cycle_expired = 1; cyc();
        chk("R6 expiry after sync no set", rd_data, 8'h00);
        link_en = 0; cyc();
        link_en = 1; cyc();
        cycle_expired = 1; cyc();
        chk("R6 sync forgotten after re-enable", rd_data, 8'h10);
        link_en = 0; cyc();
        chk("R7 cleared again", rd_data, 8'h00);
    endtask

    task automatic t_improper();
        lcv_done = 1; lcv_len = 4'd3; cyc();
        chk("R8 length 3 is proper", rd_data, 8'h00);
        lcv_done = 1; lcv_len = 4'd2; cyc();
        chk("R8 length 2 improper", rd_data, 8'h02);
        wr(8'h00);
        chk("R11 write 0 keeps improper", rd_data, 8'h02);
        wr(8'h02);
        chk("R8 write 1 clears improper", rd_data, 8'h00);
    endtask

    task automatic t_txfail();
        tx_fail_evt = 1; cyc();
        chk("R9 tx fail flag set", rd_data, 8'h01);
        chk("R9 tx_req_clear pulse", {7'b0, tx_req_clear}, 8'h01);
        cyc();
        chk("R9 tx_req_clear one cycle", {7'b0, tx_req_clear}, 8'h00);
        wr(8'h02);
        chk("R11 other-bit write keeps tx fail", rd_data, 8'h01);
        wr(8'h01);
        chk("R9 write 1 clears tx fail", rd_data, 8'h00);
    endtask

    task automatic t_set_wins();
        tx_fail_evt = 1; lcv_done = 1; lcv_len = 4'd1;
        coll_pulse = 1; tx_phase = 2'b10; cyc();
        chk("R10 flags set", rd_data, 8'h0B);
        tx_fail_evt = 1; lcv_done = 1; lcv_len = 4'd0;
        coll_pulse = 1; tx_phase = 2'b01;
        wr_en = 1; wr_data = 8'h0F; cyc();
        chk("R10 set beats clear", rd_data, 8'h07);
        wr(8'h0F);
        chk("R10 later clear works", rd_data, 8'h00);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_coll_encode();
        t_coll_idle();
        t_coll_sticky();
        t_sync();
        t_improper();
        t_txfail();
        t_set_wins();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule